// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for the instruction sitting in the execute stage of a five-stage in-order pipeline, where each of its two ALU operands must come from. An operand can come from the register-file value latched when the instruction was decoded. It can also come from the result held one stage ahead, in the memory stage, or from the result two stages ahead, in the write-back stage. The choice depends on whether a later instruction writes the register that this operand reads.

The unit compares the two source register numbers with the destination numbers and write flags of the two later stages. From that it produces one 2-bit select for each operand. The same top level also contains the two 3-input operand multiplexers and the 2-to-1 multiplexer that puts the sign-extended immediate on the second ALU input. This lets the data paths be checked end to end. The forwarded second-source value is always available on a separate store-data output, whether or not the immediate is selected.

The block is purely combinational and has no clock or reset.

Top module: `opfwd_exec`

## Requirements
- R1: `sel_a` is 2'b10 when `mem_wr_en` is 1, `mem_dst` is non-zero, and `mem_dst` equals `ex_rs_idx`.
- R2: `sel_b` is 2'b10 when `mem_wr_en` is 1, `mem_dst` is non-zero, and `mem_dst` equals `ex_rt_idx`.
- R3: An operand select is 2'b01 when all of the following hold: `wb_wr_en` is 1, `wb_dst` is non-zero, `wb_dst` equals that operand's source index, and the R1/R2 condition for that operand does not hold.
- R4: When both later stages write the same non-zero register that an operand reads, that operand's select is 2'b10, so the newer memory-stage result wins.
- R5: A destination of register 0 never causes forwarding on either path, whatever the write flags are.
- R6: When no forwarding condition holds, a select is 2'b00 (the register-file value). The value 2'b11 never appears.
- R7: `alu_a` equals `ex_rs_val`, `wb_result` or `mem_result` when `sel_a` is 2'b00, 2'b01 or 2'b10 respectively. `store_data` follows `sel_b` over `ex_rt_val`, `wb_result` and `mem_result` in the same way.
- R8: `alu_b` equals `ex_imm` when `ex_use_imm` is 1; otherwise it equals `store_data`. `ex_use_imm` has no effect on `sel_b` or `store_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | First source register number of the execute-stage instruction |
| ex_rt_idx | input | 5 | Second source register number of the execute-stage instruction |
| ex_rs_val | input | 32 | Register-file value read for the first source |
| ex_rt_val | input | 32 | Register-file value read for the second source |
| ex_imm | input | 32 | Sign-extended immediate of the execute-stage instruction |
| ex_use_imm | input | 1 | Selects the immediate as the second ALU operand |
| mem_wr_en | input | 1 | Memory-stage instruction writes the register file |
| mem_dst | input | 5 | Memory-stage destination register number |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_wr_en | input | 1 | Write-back-stage instruction writes the register file |
| wb_dst | input | 5 | Write-back-stage destination register number |
| wb_result | input | 32 | Write-back-stage result |
| sel_a | output | 2 | Source select for the first operand |
| sel_b | output | 2 | Source select for the second operand |
| alu_a | output | 32 | First ALU operand |
| alu_b | output | 32 | Second ALU operand |
| store_data | output | 32 | Forwarded second-source value for stores |

## Verification
The hardest situation to reach is a three-way collision. Both later stages write the same non-zero register, and both source fields name it. This is made harder when the write flags vary independently, because only they decide whether the older write-back result may be used. Uniform random register numbers almost never line up like that. The random stimulus therefore draws every register number from a pool of four values that includes register 0, which makes matches, double matches and zero-destination writes common. Directed vectors then pin down each collision, including register 0 written by both stages.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    // Operand source encodings; the values are visible on the select ports.
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } fwd_src_e;

endpackage

// File: rtl/opfwd_select.sv
module opfwd_select
    import opfwd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src_idx,
    input  logic          mem_wr,
    input  logic [RW-1:0] mem_dst,
    input  logic          wb_wr,
    input  logic [RW-1:0] wb_dst,
    output fwd_src_e      sel
);

    localparam logic [RW-1:0] ZERO_REG = '0;

    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_wr && (mem_dst != ZERO_REG) && (mem_dst == src_idx);
        wb_hit  = wb_wr  && (wb_dst  != ZERO_REG) && (wb_dst  == src_idx);
        // The newer memory-stage producer takes precedence.
        if (mem_hit) begin
            sel = SRC_MEM;
        end else if (wb_hit) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_src_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] wb_val,
    input  logic [DW-1:0] mem_val,
    output logic [DW-1:0] y
);

    always_comb begin
        case (sel)
            SRC_MEM: y = mem_val;
            SRC_WB:  y = wb_val;
            default: y = rf_val;
        endcase
    end

endmodule

// File: rtl/opfwd_exec.sv
module opfwd_exec
    import opfwd_pkg::*;
#(
    parameter int DW = 32,
    parameter int RW = 5
) (
    input  logic [RW-1:0] ex_rs_idx,
    input  logic [RW-1:0] ex_rt_idx,
    input  logic [DW-1:0] ex_rs_val,
    input  logic [DW-1:0] ex_rt_val,
    input  logic [DW-1:0] ex_imm,
    input  logic          ex_use_imm,
    input  logic          mem_wr_en,
    input  logic [RW-1:0] mem_dst,
    input  logic [DW-1:0] mem_result,
    input  logic          wb_wr_en,
    input  logic [RW-1:0] wb_dst,
    input  logic [DW-1:0] wb_result,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] alu_a,
    output logic [DW-1:0] alu_b,
    output logic [DW-1:0] store_data
);

    localparam int NOPS = 2;

    logic [NOPS-1:0][RW-1:0] src_idx;
    logic [NOPS-1:0][DW-1:0] rf_val;
    logic [NOPS-1:0][DW-1:0] fwd_val;
    fwd_src_e                src_sel [NOPS];

    always_comb begin
        src_idx[0] = ex_rs_idx;
        src_idx[1] = ex_rt_idx;
        rf_val[0]  = ex_rs_val;
        rf_val[1]  = ex_rt_val;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        opfwd_select #(.RW(RW)) i_select (
            .src_idx (src_idx[g]),
            .mem_wr  (mem_wr_en),
            .mem_dst (mem_dst),
            .wb_wr   (wb_wr_en),
            .wb_dst  (wb_dst),
            .sel     (src_sel[g])
        );

        opfwd_mux #(.DW(DW)) i_mux (
            .sel     (src_sel[g]),
            .rf_val  (rf_val[g]),
            .wb_val  (wb_result),
            .mem_val (mem_result),
            .y       (fwd_val[g])
        );
    end

    always_comb begin
        sel_a      = src_sel[0];
        sel_b      = src_sel[1];
        alu_a      = fwd_val[0];
        store_data = fwd_val[1];
        alu_b      = ex_use_imm ? ex_imm : fwd_val[1];
    end

endmodule

// File: rtl/opfwd_exec_chk.sv
module opfwd_exec_chk #(
    parameter int DW = 32,
    parameter int RW = 5
) (
    input logic [RW-1:0] ex_rs_idx,
    input logic [RW-1:0] ex_rt_idx,
    input logic [DW-1:0] ex_rs_val,
    input logic [DW-1:0] ex_rt_val,
    input logic [DW-1:0] ex_imm,
    input logic          ex_use_imm,
    input logic          mem_wr_en,
    input logic [RW-1:0] mem_dst,
    input logic [DW-1:0] mem_result,
    input logic          wb_wr_en,
    input logic [RW-1:0] wb_dst,
    input logic [DW-1:0] wb_result,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] alu_a,
    input logic [DW-1:0] alu_b,
    input logic [DW-1:0] store_data
);

    always_comb begin
        if (mem_wr_en && mem_dst != '0 && mem_dst == ex_rs_idx) begin
            p_mem_fwd_a_r1: assert (sel_a == 2'b10);
        end
        if (mem_wr_en && mem_dst != '0 && mem_dst == ex_rt_idx) begin
            p_mem_fwd_b_r2: assert (sel_b == 2'b10);
        end
        if (sel_a == 2'b01) begin
            p_wb_only_a_r3: assert (wb_wr_en && wb_dst == ex_rs_idx && wb_dst != '0);
        end
        if (sel_b == 2'b01) begin
            p_wb_only_b_r3: assert (wb_wr_en && wb_dst == ex_rt_idx && wb_dst != '0);
        end
        if (ex_rs_idx == '0) begin
            p_zero_a_r5: assert (sel_a == 2'b00);
        end
        if (ex_rt_idx == '0) begin
            p_zero_b_r5: assert (sel_b == 2'b00);
        end
        p_no_sel3_r6: assert (sel_a != 2'b11 && sel_b != 2'b11);
        if (sel_a == 2'b10) begin
            p_data_a_r7: assert (alu_a == mem_result);
        end
        if (sel_b == 2'b01) begin
            p_data_b_r7: assert (store_data == wb_result);
        end
        if (ex_use_imm) begin
            p_imm_r8: assert (alu_b == ex_imm);
        end else begin
            p_noimm_r8: assert (alu_b == store_data);
        end
    end

endmodule

bind opfwd_exec opfwd_exec_chk #(.DW(DW), .RW(RW)) i_opfwd_exec_chk (.*);

// File: tb/test_opfwd_exec.sv
`timescale 1ns/1ps
module test_opfwd_exec;

    localparam int DW = 32;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic [RW-1:0] ex_rs_idx, ex_rt_idx, mem_dst, wb_dst;
    logic [DW-1:0] ex_rs_val, ex_rt_val, ex_imm, mem_result, wb_result;
    logic          ex_use_imm, mem_wr_en, wb_wr_en;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] alu_a, alu_b, store_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opfwd_exec #(.DW(DW), .RW(RW)) i_opfwd_exec (.*);

    function automatic logic [1:0] exp_sel(logic [RW-1:0] src, logic mw, logic [RW-1:0] md,
                                           logic ww, logic [RW-1:0] wd);
        if (mw && md != 0 && md == src) return 2'b10;
        if (ww && wd != 0 && wd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] exp_val(logic [1:0] s, logic [DW-1:0] rf);
        return (s == 2'b10) ? mem_result : (s == 2'b01) ? wb_result : rf;
    endfunction

    function automatic string sel_tag(logic [1:0] s, logic [RW-1:0] src);
        if (src == 0) return "R5";
        if (s == 2'b10) return (mem_dst == wb_dst && wb_wr_en) ? "R4" : "R1/R2";
        if (s == 2'b01) return "R3";
        return "R6";
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [RW-1:0] rs, logic [RW-1:0] rt, logic mw, logic [RW-1:0] md,
                         logic ww, logic [RW-1:0] wd, logic ui);
        @(negedge clk);
        ex_rs_idx = rs; ex_rt_idx = rt; mem_wr_en = mw; mem_dst = md;
        wb_wr_en = ww; wb_dst = wd; ex_use_imm = ui;
        ex_rs_val = $urandom; ex_rt_val = $urandom; ex_imm = $urandom;
        mem_result = $urandom; wb_result = $urandom;
        #2;
    endtask

    task automatic check_all();
        logic [1:0] ea, eb;
        logic [DW-1:0] eva, evs;
        ea  = exp_sel(ex_rs_idx, mem_wr_en, mem_dst, wb_wr_en, wb_dst);
        eb  = exp_sel(ex_rt_idx, mem_wr_en, mem_dst, wb_wr_en, wb_dst);
        eva = exp_val(ea, ex_rs_val);
        evs = exp_val(eb, ex_rt_val);
        chk({sel_tag(ea, ex_rs_idx), " sel_a"}, DW'(sel_a), DW'(ea));
        chk({sel_tag(eb, ex_rt_idx), " sel_b"}, DW'(sel_b), DW'(eb));
        chk("R7 alu_a", alu_a, eva);
        chk("R7 store_data", store_data, evs);
        chk("R8 alu_b", alu_b, ex_use_imm ? ex_imm : evs);
    endtask

    initial begin
        void'($urandom(32'd20240613));
        // Idle state: all zero inputs give register-file selects (R6)
        @(negedge clk);
        ex_rs_idx = '0; ex_rt_idx = '0; ex_rs_val = '0; ex_rt_val = '0; ex_imm = '0;
        ex_use_imm = 0; mem_wr_en = 0; mem_dst = '0; mem_result = '0;
        wb_wr_en = 0; wb_dst = '0; wb_result = '0;
        #2;
        chk("R6 idle sel_a", DW'(sel_a), 0);
        chk("R6 idle sel_b", DW'(sel_b), 0);

        // R1: memory stage only, first operand
        apply(5'd3, 5'd4, 1, 5'd3, 0, 5'd3, 0);
        chk("R1 sel_a", DW'(sel_a), 2); chk("R1 alu_a", alu_a, mem_result);
        // R2: memory stage only, second operand
        apply(5'd7, 5'd9, 1, 5'd9, 1, 5'd7, 0);
        chk("R2 sel_b", DW'(sel_b), 2); chk("R3 sel_a", DW'(sel_a), 1);
        // R3: write-back only
        apply(5'd12, 5'd12, 0, 5'd12, 1, 5'd12, 0);
        chk("R3 sel_a", DW'(sel_a), 1); chk("R3 sel_b", DW'(sel_b), 1);
        chk("R7 store_data wb", store_data, wb_result);
        // R4: both stages target the same register
        apply(5'd5, 5'd5, 1, 5'd5, 1, 5'd5, 0);
        chk("R4 sel_a", DW'(sel_a), 2); chk("R4 sel_b", DW'(sel_b), 2);
        // R3: memory stage matches but does not write, write-back used
        apply(5'd6, 5'd1, 0, 5'd6, 1, 5'd6, 0);
        chk("R3 sel_a nowrite", DW'(sel_a), 1);
        // R5: register 0 written by both stages
        apply(5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 0);
        chk("R5 sel_a", DW'(sel_a), 0); chk("R5 sel_b", DW'(sel_b), 0);
        chk("R5 alu_a", alu_a, ex_rs_val);
        // R8: immediate selected, forwarding still reaches store data
        apply(5'd2, 5'd8, 1, 5'd8, 0, 5'd0, 1);
        chk("R8 alu_b imm", alu_b, ex_imm);
        chk("R8 sel_b unaffected", DW'(sel_b), 2);
        chk("R8 store_data", store_data, mem_result);

        for (int i = 0; i < 600; i++) begin
            logic [RW-1:0] pool [4];
            pool[0] = 5'd0; pool[1] = 5'd1; pool[2] = 5'd17; pool[3] = 5'd31;
            apply(pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)],
                  1'($urandom), pool[$urandom_range(0, 3)],
                  1'($urandom), pool[$urandom_range(0, 3)], 1'($urandom));
            check_all();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule